// File: doc/BRIEF.md
# Parallel Flash Command Interface

A clocked behavioural model of the command side of a parallel NOR-style flash, backed by a small register array. A host drives active-low chip-enable, write-enable and output-enable strobes together with address and data buses. On every clock edge the block samples the strobes. It decodes multi-cycle unlock sequences that program words or bytes, erase sectors or the whole array, expose an identifier register, or enter a fast two-cycle program mode. A per-sector protection bitmap, fixed by parameter, silently blocks program and erase. An accelerate input forces the fast program mode and overrides the bitmap while it is held.

Program and erase start a busy window whose length comes from a parameterised cycle count. Command writes arriving while it is open are dropped. Reads are combinational from the address bus. The block is meant as a stand-in for a flash device in a larger system model, or as the command front end of an emulated memory. The unlock addresses are the low address bits of 0x555 and 0x2AA. With the default 6-bit address these are 0x15 and 0x2A. A sector is chosen by the top `SB` address bits.

Top module: `flash_cmd_top`

## Requirements
- R1: Reset (rst_ni low) puts the machine in array-read mode, clears any partial sequence and the fast-program flag, drops busy_o, and initialises every array word to 0xFFFF. Array data is readable with no command.
- R2: A command write is a clock edge at which ce_ni=0, we_ni=0 and oe_ni=1. When ce_ni=0, oe_ni=0 and we_ni=1, data_o shows the addressed word. Otherwise data_o is 0.
- R3: Writing 0xAA@0x15, 0x55@0x2A, 0xA0@0x15 and then a data write at the target address programs that word to old AND data. Programming only clears bits.
- R4: With byte_ni=0, program data is taken from data_i[7:0] into the low byte and the high byte is kept. Array reads return {8'h00, low byte}.
- R5: A write that breaks an unlock sequence, or a write not recognised in read mode (including 0xF0), leaves or keeps the machine in array-read mode. Only the low 8 data bits are decoded as commands.
- R6: 0xAA@0x15, 0x55@0x2A, 0x90@0x15 enters identifier mode. In that mode a read returns {8'h00, code}. The code is MFR_ID when addr[1:0]=0 and DEV_ID when it is 1. When it is 2, the code is the protection bit of the addressed sector. Any other low address gives 0. Any write returns to array-read mode.
- R7: 0xAA@0x15, 0x55@0x2A, 0x20@0x15 enters fast-program mode. There, 0xA0 at any address followed by a data write programs in two cycles, and the mode is kept afterwards. Any other write leaves the mode.
- R8: 0xAA@0x15, 0x55@0x2A, 0x80@0x15, 0xAA@0x15, 0x55@0x2A, then 0x30 at a sector address selects that sector. Further 0x30 writes, each arriving within SE_WIN idle cycles of the previous one, add sectors. When the window runs out, all selected sectors become 0xFFFF. Any non-0x30 write in the window aborts the erase.
- R9: The same five-write prefix followed by 0x10@0x15 sets every unprotected sector to 0xFFFF.
- R10: After a program data write, busy_o is high for exactly PROG_CYC cycles, starting at the next edge. An erase gives ERASE_CYC cycles. Command writes while busy_o is high are ignored.
- R11: Program or erase aimed at a sector whose PROT_INIT bit is 1 is dropped without changing data. A dropped program raises no busy.
- R12: While acc_i=1, 0xA0 plus a data write programs from read mode with no unlock, and protection is ignored. After acc_i returns to 0, protection applies again and a lone 0xA0 is an unrecognised write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| byte_ni | input | 1 | 0 selects byte data width, 1 word width |
| acc_i | input | 1 | Accelerate: forces fast program, overrides protection |
| addr_i | input | AW | Word address |
| data_i | input | 16 | Write data / command code |
| data_o | output | 16 | Read data, 0 when not reading |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The bench aims at places where the state machine could leak. One case is a data cycle with output-enable low; a design that treats it as a write programs the wrong word. Another is an identifier command sent during a busy window; if it is not ignored, later reads return codes instead of array data. A partial unlock is cut by reset, and a misdecoded break would let a trailing program go through. Sector erase is checked both with two collected sectors and with an abort. An abort that does not clear the selection would wipe a sector. Protection is exercised with and without accelerate, and against chip erase. A design that forgets the protected sector, or keeps the override after release, leaves visibly wrong words. The busy length is sampled at its last high cycle and its first low cycle, which exposes off-by-one counters.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PROG, S_ASEL, S_E0, S_E1, S_E2, S_COL
  } fsm_e;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ASEL  = 8'h90;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_FAST  = 8'h20;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW     = 6,
  parameter int SB     = 2,
  parameter int SE_WIN = 6,
  localparam int SECT  = 1 << SB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     cmd_i,
  input  logic            byte_mode_i,
  input  logic            acc_i,
  input  logic [SECT-1:0] prot_i,
  output logic            prog_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [15:0]     prog_mask_o,
  output logic            erase_o,
  output logic [SECT-1:0] erase_sel_o,
  output logic            asel_o
);
  localparam int TW = $clog2(SE_WIN + 1);
  localparam logic [AW-1:0] UA1 = AW'(12'h555);
  localparam logic [AW-1:0] UA2 = AW'(12'h2AA);

  fsm_e            st_q, st_d;
  logic            fast_q, fast_d;
  logic [SECT-1:0] sel_q, sel_d;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic [7:0]      c;
  logic [SB-1:0]   sec;
  logic            at_u1, at_u2;

  assign c     = cmd_i[7:0];
  assign sec   = addr_i[AW-1 -: SB];
  assign at_u1 = (addr_i == UA1);
  assign at_u2 = (addr_i == UA2);

  assign prog_addr_o = addr_i;
  assign prog_mask_o = byte_mode_i ? {8'hFF, cmd_i[7:0]} : cmd_i;
  assign asel_o      = (st_q == S_ASEL);

  always_comb begin
    st_d        = st_q;
    fast_d      = fast_q;
    sel_d       = sel_q;
    tmr_d       = tmr_q;
    prog_o      = 1'b0;
    erase_o     = 1'b0;
    erase_sel_o = '0;
    unique case (st_q)
      S_READ: if (wr_i) begin
        if (fast_q || acc_i) begin
          if (c == C_PROG) st_d = S_PROG;
          else             fast_d = 1'b0;
        end else if (at_u1 && c == C_UNL1) begin
          st_d = S_U1;
        end
      end
      S_U1: if (wr_i) st_d = (at_u2 && c == C_UNL2) ? S_U2 : S_READ;
      S_U2: if (wr_i) begin
        st_d = S_READ;
        if (at_u1) begin
          case (c)
            C_PROG:  st_d = S_PROG;
            C_ASEL:  st_d = S_ASEL;
            C_ERASE: st_d = S_E0;
            C_FAST:  fast_d = 1'b1;
            default: st_d = S_READ;
          endcase
        end
      end
      S_PROG: if (wr_i) begin
        st_d   = S_READ;
        prog_o = ~prot_i[sec];
      end
      S_ASEL: if (wr_i) st_d = S_READ;
      S_E0: if (wr_i) st_d = (at_u1 && c == C_UNL1) ? S_E1 : S_READ;
      S_E1: if (wr_i) st_d = (at_u2 && c == C_UNL2) ? S_E2 : S_READ;
      S_E2: if (wr_i) begin
        st_d = S_READ;
        if (at_u1 && c == C_CHIP) begin
          erase_o     = 1'b1;
          erase_sel_o = ~prot_i;
        end else if (c == C_SECT) begin
          st_d  = S_COL;
          sel_d = SECT'(1) << sec;
          tmr_d = TW'(SE_WIN);
        end
      end
      S_COL: begin
        if (wr_i) begin
          if (c == C_SECT) begin
            sel_d = sel_q | (SECT'(1) << sec);
            tmr_d = TW'(SE_WIN);
          end else begin
            st_d = S_READ;
          end
        end else if (tmr_q == '0) begin
          erase_o     = 1'b1;
          erase_sel_o = sel_q & ~prot_i;
          st_d        = S_READ;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = S_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_READ;
      fast_q <= 1'b0;
      sel_q  <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_d;
      fast_q <= fast_d;
      sel_q  <= sel_d;
      tmr_q  <= tmr_d;
    end
  end
endmodule

// File: rtl/flash_cmd_busy.sv
module flash_cmd_busy #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  localparam int MAXC     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_i,
  input  logic erase_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (prog_i)        cnt_q <= CW'(PROG_CYC);
    else if (erase_i)       cnt_q <= CW'(ERASE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
  parameter int AW    = 6,
  parameter int SB    = 2,
  parameter int DW    = 16,
  localparam int WORDS = 1 << AW,
  localparam int SECT  = 1 << SB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_i,
  input  logic [AW-1:0]   prog_addr_i,
  input  logic [DW-1:0]   prog_mask_i,
  input  logic            erase_i,
  input  logic [SECT-1:0] erase_sel_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o
);
  logic [DW-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int SI = w >> (AW - SB);
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    word_q <= '1;
      else if (erase_i && erase_sel_i[SI])            word_q <= '1;
      else if (prog_i && prog_addr_i == AW'(w))       word_q <= word_q & prog_mask_i;
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
  parameter int AW        = 6,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  parameter int SE_WIN    = 6,
  parameter logic [(1<<SB)-1:0] PROT_INIT = 4'b0100,
  parameter logic [7:0] MFR_ID = 8'h3C,
  parameter logic [7:0] DEV_ID = 8'hB5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          byte_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  output logic [15:0]   data_o,
  output logic          busy_o
);
  localparam int SECT = 1 << SB;

  logic            wr_w, rd_w;
  logic [SECT-1:0] prot_eff;
  logic            prog_w, erase_w, asel_w;
  logic [AW-1:0]   prog_addr_w;
  logic [15:0]     prog_mask_w, arr_w;
  logic [SECT-1:0] erase_sel_w;
  logic [7:0]      id_w;

  assign wr_w     = ~ce_ni & ~we_ni & oe_ni & ~busy_o;
  assign rd_w     = ~ce_ni & ~oe_ni & we_ni;
  assign prot_eff = PROT_INIT & {SECT{~acc_i}};

  flash_cmd_decoder #(.AW(AW), .SB(SB), .SE_WIN(SE_WIN)) u_dec (
    .clk_i, .rst_ni,
    .wr_i        (wr_w),
    .addr_i,
    .cmd_i       (data_i),
    .byte_mode_i (~byte_ni),
    .acc_i,
    .prot_i      (prot_eff),
    .prog_o      (prog_w),
    .prog_addr_o (prog_addr_w),
    .prog_mask_o (prog_mask_w),
    .erase_o     (erase_w),
    .erase_sel_o (erase_sel_w),
    .asel_o      (asel_w)
  );

  flash_cmd_busy #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_busy (
    .clk_i, .rst_ni,
    .prog_i  (prog_w),
    .erase_i (erase_w),
    .busy_o
  );

  flash_cmd_array #(.AW(AW), .SB(SB), .DW(16)) u_arr (
    .clk_i, .rst_ni,
    .prog_i      (prog_w),
    .prog_addr_i (prog_addr_w),
    .prog_mask_i (prog_mask_w),
    .erase_i     (erase_w),
    .erase_sel_i (erase_sel_w),
    .rd_addr_i   (addr_i),
    .rd_data_o   (arr_w)
  );

  always_comb begin
    unique case (addr_i[1:0])
      2'd0:    id_w = MFR_ID;
      2'd1:    id_w = DEV_ID;
      2'd2:    id_w = {7'b0, PROT_INIT[addr_i[AW-1 -: SB]]};
      default: id_w = 8'h00;
    endcase
  end

  always_comb begin
    if (!rd_w)        data_o = '0;
    else if (asel_w)  data_o = {8'h00, id_w};
    else if (!byte_ni) data_o = {8'h00, arr_w[7:0]};
    else              data_o = arr_w;
  end
endmodule

// File: rtl/flash_cmd_sva.sv
module flash_cmd_sva #(
  parameter int AW        = 6,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  parameter logic [(1<<SB)-1:0] PROT_INIT = 4'b0100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          we_ni,
  input logic          oe_ni,
  input logic          byte_ni,
  input logic          acc_i,
  input logic [15:0]   data_o,
  input logic          busy_o,
  input logic          prog_i,
  input logic          erase_i,
  input logic          asel_i,
  input logic [AW-1:0] prog_addr_i
);
  logic [15:0] run_q;
  logic        rd;
  assign rd = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r2_quiet_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> data_o == 16'h0);

  a_r4_byte_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !byte_ni) |-> data_o[15:8] == 8'h00);

  a_r6_id_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && asel_i) |-> data_o[15:8] == 8'h00);

  a_r10_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !prog_i && !erase_i);

  a_r10_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 16'(PROG_CYC) || run_q == 16'(ERASE_CYC)));

  a_r11_prot_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !acc_i) |-> !PROT_INIT[prog_addr_i[AW-1 -: SB]]);
endmodule

bind flash_cmd_top flash_cmd_sva #(
  .AW(AW), .SB(SB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_INIT(PROT_INIT)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
  .byte_ni(byte_ni), .acc_i(acc_i), .data_o(data_o), .busy_o(busy_o),
  .prog_i(prog_w), .erase_i(erase_w), .asel_i(asel_w), .prog_addr_i(prog_addr_w)
);

// File: tb/flash_cmd_top_bench.sv
module flash_cmd_top_bench;
  localparam int PROG_CYC = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, byte_ni = 1'b1, acc_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        busy_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  flash_cmd_top u_flash_cmd_top (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic        bm;
    logic [5:0]  a;
    logic [15:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OI = 2'd2;
  localparam int N = 63;
  localparam vec_t TBL [N] = '{
    '{OW,0,6'h15,16'h00AA,3}, '{OW,0,6'h2A,16'h0055,3}, '{OW,0,6'h15,16'h00A0,3},
    '{OW,0,6'h05,16'h1234,3}, '{OI,0,6'h00,16'h0000,3},
    '{OR,0,6'h05,16'h1234,3},                               // R3 program
    '{OW,0,6'h15,16'h00AA,3}, '{OW,0,6'h2A,16'h0055,3}, '{OW,0,6'h15,16'h00A0,3},
    '{OW,0,6'h05,16'hFF0F,3}, '{OI,0,6'h00,16'h0000,3},
    '{OR,0,6'h05,16'h1204,3},                               // R3 only clears bits
    '{OW,0,6'h15,16'h00AA,4}, '{OW,0,6'h2A,16'h0055,4}, '{OW,0,6'h15,16'h00A0,4},
    '{OW,1,6'h06,16'h12C3,4}, '{OI,0,6'h00,16'h0000,4},
    '{OR,0,6'h06,16'hFFC3,4}, '{OR,1,6'h06,16'h00C3,4},     // R4 byte lane
    '{OW,0,6'h15,16'h00AA,6}, '{OW,0,6'h2A,16'h0055,6}, '{OW,0,6'h15,16'h0090,6},
    '{OR,0,6'h00,16'h003C,6}, '{OR,0,6'h01,16'h00B5,6},
    '{OR,0,6'h22,16'h0001,6}, '{OR,0,6'h02,16'h0000,6},     // R6 identifier
    '{OW,0,6'h00,16'h00F0,6}, '{OR,0,6'h05,16'h1204,6},
    '{OW,0,6'h15,16'h00AA,5}, '{OW,0,6'h15,16'h0055,5}, '{OW,0,6'h15,16'h00A0,5},
    '{OW,0,6'h07,16'h0000,5}, '{OR,0,6'h07,16'hFFFF,5},     // R5 broken unlock
    '{OW,0,6'h15,16'h00AA,7}, '{OW,0,6'h2A,16'h0055,7}, '{OW,0,6'h15,16'h0020,7},
    '{OW,0,6'h00,16'h00A0,7}, '{OW,0,6'h08,16'h00F0,7}, '{OI,0,6'h00,16'h0000,7},
    '{OR,0,6'h08,16'h00F0,7},                               // R7 fast program
    '{OW,0,6'h00,16'h00A0,7}, '{OW,0,6'h09,16'h0F00,7}, '{OI,0,6'h00,16'h0000,7},
    '{OR,0,6'h09,16'h0F00,7},
    '{OW,0,6'h00,16'h00F0,7}, '{OW,0,6'h15,16'h00A0,7}, '{OW,0,6'h0A,16'h0000,7},
    '{OR,0,6'h0A,16'hFFFF,7},                               // R7 exit
    '{OW,0,6'h15,16'h00AA,11}, '{OW,0,6'h2A,16'h0055,11}, '{OW,0,6'h15,16'h00A0,11},
    '{OW,0,6'h25,16'h0000,11}, '{OR,0,6'h25,16'hFFFF,11},   // R11 protected
    '{OW,0,6'h15,16'h00AA,9}, '{OW,0,6'h2A,16'h0055,9}, '{OW,0,6'h15,16'h0080,9},
    '{OW,0,6'h15,16'h00AA,9}, '{OW,0,6'h2A,16'h0055,9}, '{OW,0,6'h15,16'h0010,9},
    '{OI,0,6'h00,16'h0000,9},
    '{OR,0,6'h05,16'hFFFF,9}, '{OR,0,6'h06,16'hFFFF,9}, '{OR,0,6'h08,16'hFFFF,9} // R9 chip
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ce, input logic we, input logic oe, input logic bm,
                     input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i);
    ce_ni = ce; we_ni = we; oe_ni = oe; byte_ni = ~bm; addr_i = a; data_i = d;
    @(negedge clk_i);
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1; byte_ni = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [5:0] a, input logic bm, output logic [15:0] v);
    #1;
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; byte_ni = ~bm; addr_i = a;
    #1 v = data_o;
    ce_ni = 1'b1; oe_ni = 1'b1; byte_ni = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic unlock2();
    wr(6'h15, 16'h00AA); wr(6'h2A, 16'h0055);
  endtask

  task automatic program_word(input logic [5:0] a, input logic [15:0] d);
    unlock2(); wr(6'h15, 16'h00A0); wr(a, d); wait_idle();
  endtask

  task automatic erase_prefix();
    unlock2(); wr(6'h15, 16'h0080); unlock2();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(1, {15'b0, busy_o}, 16'h0);
    rd(6'h00, 1'b0, v); check(1, v, 16'hFFFF);
    // R2 no read strobe -> zero output
    #1 ce_ni = 1'b1; oe_ni = 1'b0; #1 check(2, data_o, 16'h0); oe_ni = 1'b1;

    for (int i = 0; i < N; i++) begin
      case (TBL[i].op)
        OW: cyc(1'b0, 1'b0, 1'b1, TBL[i].bm, TBL[i].a, TBL[i].d);
        OR: begin rd(TBL[i].a, TBL[i].bm, v); check(int'(TBL[i].req), v, TBL[i].d); end
        default: wait_idle();
      endcase
    end

    // R2 data cycle with oe low is not a write
    unlock2(); wr(6'h15, 16'h00A0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 6'h0B, 16'h0000);
    wr(6'h0B, 16'h5555); wait_idle();
    rd(6'h0B, 1'b0, v); check(2, v, 16'h5555);

    // R10 exact busy length
    unlock2(); wr(6'h15, 16'h00A0); wr(6'h0C, 16'h00FF);
    check(10, {15'b0, busy_o}, 16'h1);
    repeat (PROG_CYC - 1) @(negedge clk_i);
    check(10, {15'b0, busy_o}, 16'h1);
    @(negedge clk_i);
    check(10, {15'b0, busy_o}, 16'h0);

    // R10 writes during busy ignored
    unlock2(); wr(6'h15, 16'h00A0); wr(6'h0D, 16'h0000);
    unlock2(); wr(6'h15, 16'h0090);
    wait_idle();
    rd(6'h00, 1'b0, v); check(10, v, 16'hFFFF);

    // R8 multi-sector erase
    program_word(6'h11, 16'h0000);
    program_word(6'h31, 16'h0000);
    program_word(6'h01, 16'h0000);
    erase_prefix(); wr(6'h10, 16'h0030); wr(6'h30, 16'h0030);
    repeat (12) @(negedge clk_i);
    wait_idle();
    rd(6'h11, 1'b0, v); check(8, v, 16'hFFFF);
    rd(6'h31, 1'b0, v); check(8, v, 16'hFFFF);
    rd(6'h01, 1'b0, v); check(8, v, 16'h0000);
    // R8 abort
    erase_prefix(); wr(6'h00, 16'h0030); wr(6'h00, 16'h00F0);
    repeat (12) @(negedge clk_i);
    wait_idle();
    rd(6'h01, 1'b0, v); check(8, v, 16'h0000);

    // R12 accelerate overrides protection, two-cycle program
    acc_i = 1'b1;
    wr(6'h00, 16'h00A0); wr(6'h25, 16'h0F0F); wait_idle();
    rd(6'h25, 1'b0, v); check(12, v, 16'h0F0F);
    acc_i = 1'b0;
    wr(6'h00, 16'h00A0); wr(6'h26, 16'h0000); wait_idle();
    rd(6'h26, 1'b0, v); check(12, v, 16'hFFFF);
    // R11 protection back after release: program dropped, no busy
    unlock2(); wr(6'h15, 16'h00A0); wr(6'h25, 16'h0000);
    check(11, {15'b0, busy_o}, 16'h0);
    rd(6'h25, 1'b0, v); check(11, v, 16'h0F0F);
    // R11 chip erase skips protected sector
    erase_prefix(); wr(6'h15, 16'h0010); wait_idle();
    rd(6'h25, 1'b0, v); check(11, v, 16'h0F0F);
    rd(6'h01, 1'b0, v); check(9, v, 16'hFFFF);

    // R1 reset clears a partial sequence
    unlock2();
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    wr(6'h15, 16'h00A0); wr(6'h04, 16'h0000); wait_idle();
    rd(6'h04, 1'b0, v); check(1, v, 16'hFFFF);
    check(1, {15'b0, busy_o}, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule